// File: doc/BRIEF.md
# SPI Serial Clock Generator with Programmable Duty Cycle

This block derives the serial clock of an SPI master from its input clock. A single 32-bit clock word, written through a strobe, carries a period value, a high-phase length and a clock-source select. The high and low parts of the SCK period are therefore set directly by the word rather than by a fixed half-period divider. While the transfer engine holds `run` high, the block produces SCK and two single-cycle strobes. `sample_stb` marks each rising SCK edge, where incoming data is captured. `shift_stb` marks each falling edge, where outgoing data is advanced.

An internal phase counter steps from 0 up to the period value and then wraps, so one SCK period lasts period+1 counter steps. SCK is high while the counter is at or below the high-phase value. The counter steps on every input clock, or, when the source-select bit is set, only on cycles in which the `alt_tick` enable is high. With the period value between 1 and 63, SCK runs between the input rate divided by 64 and the input rate divided by 2. A new clock word is accepted only while the engine is idle, and SCK rests low whenever `run` is low.

Top module: `spi_sck_divider`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), sck, sample_stb and shift_stb are 0. The clock word defaults to period value 1, high value 0 and internal source, so a later run gives an SCK of two cycles with one cycle high.
- R2: The period value sits in cfg_data bits 17:12. One SCK period, measured between successive sample_stb pulses, lasts period+1 counter steps.
- R3: The high value sits in cfg_data bits 11:6. In each period SCK is high for high+1 counter steps, beginning at the rising edge.
- R4: One cycle after run is sampled low, sck, sample_stb and shift_stb are all 0. In the cycle after run is first sampled high, sck is 1 and sample_stb is 1.
- R5: sample_stb is 1 exactly in the cycles where sck has just gone from 0 to 1. shift_stb is 1 exactly in the cycles where sck has just gone from 1 to 0. The two are never high together.
- R6: A write (cfg_wr high with cfg_data) is stored only when run is low at that edge. A write made while run is high is discarded and never applied.
- R7: When cfg_data bit 31 is 1, the counter advances only at edges where alt_tick is 1. When bit 31 is 0, alt_tick is ignored and the counter advances every cycle.
- R8: A period value of 0 is treated as 1.
- R9: A high value greater than or equal to the effective period value is reduced to that period value minus 1, so each period keeps at least one low step.
- R10: cfg_data bits 5:0 (the low-phase count) and bits 30:18 have no effect on the SCK waveform or the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock from which SCK is derived |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Transfer in progress; SCK toggles only while high |
| alt_tick | input | 1 | Step enable used when the alternate source is selected |
| cfg_wr | input | 1 | Write strobe for the clock word |
| cfg_data | input | 32 | Clock word: bit 31 source, 17:12 period, 11:6 high, 5:0 low count |
| sck | output | 1 | Serial clock, low when idle |
| sample_stb | output | 1 | One-cycle pulse on each rising SCK edge |
| shift_stb | output | 1 | One-cycle pulse on each falling SCK edge |

## Verification
The assertions assume that the engine never changes the clock word during a transfer, that run is driven low through reset, and that alt_tick matters only when the alternate source is selected. The stimulus writes every intended clock word with run low. The single write made during a transfer is deliberate and checks that the stored word stays frozen. The alt_tick pattern is strictly periodic, so that measured SCK periods and high times are whole multiples of the step spacing. Each scenario lets at least one full SCK period pass before it measures, so the start edge and the wrap of the counter are both covered.

// File: rtl/spi_sck_pkg.sv
// Package spi_sck_pkg
// Shared constants for the SPI clock generator: clock-word field positions,
// field width and the reset values of the stored word.
package spi_sck_pkg;
    localparam int SCK_REG_W   = 32;
    localparam int SCK_FIELD_W = 6;
    localparam int SCK_SRC_BIT = 31;
    localparam int SCK_DIV_LSB = 12;
    localparam int SCK_HI_LSB  = 6;
    localparam int SCK_LO_LSB  = 0;

    // Reset contents of the stored word: fastest rate, internal source.
    localparam logic [SCK_FIELD_W-1:0] SCK_DIV_RST = SCK_FIELD_W'(1);
    localparam logic [SCK_FIELD_W-1:0] SCK_HI_RST  = '0;

    // Decoded clock word as seen by the counter and waveform stages.
    typedef struct packed {
        logic                   alt_src;
        logic [SCK_FIELD_W-1:0] div;
        logic [SCK_FIELD_W-1:0] hi;
    } sck_cfg_t;
endpackage

// File: rtl/sck_cfg_reg.sv
// Module sck_cfg_reg
// Holds the decoded clock word. It accepts a write only while run is low.
// At load time it clamps the period value to at least 1 and the high value
// to below the period value. The low-count field and the spare bits are
// not used.
// Assumes: cfg_data is valid in the cycle cfg_wr is high.
module sck_cfg_reg #(
    parameter int REG_W   = spi_sck_pkg::SCK_REG_W,
    parameter int CNT_W   = spi_sck_pkg::SCK_FIELD_W,
    parameter int SRC_BIT = spi_sck_pkg::SCK_SRC_BIT,
    parameter int DIV_LSB = spi_sck_pkg::SCK_DIV_LSB,
    parameter int HI_LSB  = spi_sck_pkg::SCK_HI_LSB,
    parameter int LO_LSB  = spi_sck_pkg::SCK_LO_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_data,
    output logic             alt_src,
    output logic [CNT_W-1:0] div_eff,
    output logic [CNT_W-1:0] hi_eff
);
    localparam int SPARE_LSB = DIV_LSB + CNT_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] div_raw;
    logic [CNT_W-1:0] hi_raw;
    logic [CNT_W-1:0] div_new;
    logic [CNT_W-1:0] hi_new;
    logic             load;

    // Fields without effect on the waveform, gathered so they are visibly consumed.
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_data[SRC_BIT-1:SPARE_LSB], cfg_data[LO_LSB+CNT_W-1:LO_LSB]};

    // Extract the raw period and high fields from the written word.
    always_comb begin
        div_raw = cfg_data[DIV_LSB +: CNT_W];
        hi_raw  = cfg_data[HI_LSB +: CNT_W];
    end

    // Clamp the period to at least 1 and the high phase to below the period.
    always_comb begin
        div_new = (div_raw == '0) ? ONE : div_raw;
        hi_new  = (hi_raw >= div_new) ? (div_new - ONE) : hi_raw;
    end

    // A write is taken only while the engine is idle.
    assign load = cfg_wr && !run;

    // Clock-word storage with synchronous reset to the default rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_src <= 1'b0;
            div_eff <= spi_sck_pkg::SCK_DIV_RST;
            hi_eff  <= spi_sck_pkg::SCK_HI_RST;
        end else if (load) begin
            alt_src <= cfg_data[SRC_BIT];
            div_eff <= div_new;
            hi_eff  <= hi_new;
        end
    end
endmodule

// File: rtl/sck_phase_counter.sv
// Module sck_phase_counter
// Phase counter of the clock generator. In the first run cycle it arms and
// clears. After that it steps on each enabled tick from 0 up to the period
// value and wraps. When run is low it is held cleared and disarmed.
// Assumes: div_eff is at least 1 and does not change while run is high.
module sck_phase_counter #(
    parameter int CNT_W = spi_sck_pkg::SCK_FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] div_eff,
    output logic             active,
    output logic             start,
    output logic             adv,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);
    // Start in the first run cycle; advance on ticks once armed.
    always_comb begin
        start = run && !active;
        adv   = run && active && tick;
    end

    // Next count value with wrap at the period value.
    always_comb begin
        if (cnt_q == div_eff) begin
            cnt_next = '0;
        end else begin
            cnt_next = cnt_q + CNT_W'(1);
        end
    end

    // Arm flag and counter register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt_q  <= '0;
        end else if (adv) begin
            cnt_q  <= cnt_next;
        end
    end
endmodule

// File: rtl/sck_wave_gen.sv
// Module sck_wave_gen
// Registers the SCK level from the next counter value and emits one-cycle
// edge strobes in the same cycle the level changes. SCK and both strobes
// are cleared whenever run is low.
// Assumes: start and adv are never high together.
module sck_wave_gen #(
    parameter int CNT_W = spi_sck_pkg::SCK_FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [CNT_W-1:0] hi_eff,
    output logic             sck,
    output logic             sample_stb,
    output logic             shift_stb
);
    logic next_level;

    // SCK is high while the count is within the high phase.
    assign next_level = (cnt_next <= hi_eff);

    // Level and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sck        <= 1'b0;
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
        end else if (start) begin
            sck        <= 1'b1;
            sample_stb <= 1'b1;
            shift_stb  <= 1'b0;
        end else if (adv) begin
            sck        <= next_level;
            sample_stb <= next_level && !sck;
            shift_stb  <= !next_level && sck;
        end else begin
            sample_stb <= 1'b0;
            shift_stb  <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_sck_divider.sv
// Module spi_sck_divider
// Top of the SPI serial-clock generator. It joins the clock-word register,
// the phase counter and the waveform stage, and selects the step source
// (every cycle, or alt_tick cycles only).
// Assumes: the engine leaves the clock word alone during transfers.
module spi_sck_divider #(
    parameter int REG_W   = spi_sck_pkg::SCK_REG_W,
    parameter int CNT_W   = spi_sck_pkg::SCK_FIELD_W,
    parameter int SRC_BIT = spi_sck_pkg::SCK_SRC_BIT,
    parameter int DIV_LSB = spi_sck_pkg::SCK_DIV_LSB,
    parameter int HI_LSB  = spi_sck_pkg::SCK_HI_LSB,
    parameter int LO_LSB  = spi_sck_pkg::SCK_LO_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             alt_tick,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_data,
    output logic             sck,
    output logic             sample_stb,
    output logic             shift_stb
);
    logic             alt_src;
    logic [CNT_W-1:0] div_eff;
    logic [CNT_W-1:0] hi_eff;
    logic             tick;
    logic             active;
    logic             start;
    logic             adv;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    // Stored clock word.
    sck_cfg_reg #(
        .REG_W  (REG_W),
        .CNT_W  (CNT_W),
        .SRC_BIT(SRC_BIT),
        .DIV_LSB(DIV_LSB),
        .HI_LSB (HI_LSB),
        .LO_LSB (LO_LSB)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cfg_wr  (cfg_wr),
        .cfg_data(cfg_data),
        .alt_src (alt_src),
        .div_eff (div_eff),
        .hi_eff  (hi_eff)
    );

    // Step source: every cycle or alt_tick cycles only.
    assign tick = alt_src ? alt_tick : 1'b1;

    // Phase counter.
    sck_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .div_eff (div_eff),
        .active  (active),
        .start   (start),
        .adv     (adv),
        .cnt_q   (cnt_q),
        .cnt_next(cnt_next)
    );

    // SCK level and edge strobes.
    sck_wave_gen #(.CNT_W(CNT_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .start     (start),
        .adv       (adv),
        .cnt_next  (cnt_next),
        .hi_eff    (hi_eff),
        .sck       (sck),
        .sample_stb(sample_stb),
        .shift_stb (shift_stb)
    );
endmodule

// File: rtl/spi_sck_divider_chk.sv
// Module spi_sck_divider_chk
// Property checker bound into spi_sck_divider. It observes the ports and
// the counter and clock-word state; it drives nothing.
module spi_sck_divider_chk #(
    parameter int CNT_W = spi_sck_pkg::SCK_FIELD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             alt_tick,
    input logic             alt_src,
    input logic             active,
    input logic             sck,
    input logic             sample_stb,
    input logic             shift_stb,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] div_eff,
    input logic [CNT_W-1:0] hi_eff
);
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_eff);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sck && !sample_stb && !shift_stb));

    assert_sample_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (sck && !$past(sck)));

    assert_shift_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> (!sck && $past(sck)));

    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb));

    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(div_eff) && $stable(hi_eff)));

    assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && active && alt_src && !alt_tick) |=> $stable(cnt_q));
endmodule

bind spi_sck_divider spi_sck_divider_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .alt_tick  (alt_tick),
    .alt_src   (alt_src),
    .active    (active),
    .sck       (sck),
    .sample_stb(sample_stb),
    .shift_stb (shift_stb),
    .cnt_q     (cnt_q),
    .div_eff   (div_eff),
    .hi_eff    (hi_eff)
);

// File: tb/tb_spi_sck_divider.sv
// Bench for spi_sck_divider: a behavioural model compared on every clock,
// plus scenario measurements of SCK period and high time.
module tb_spi_sck_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        alt_tick = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        sck;
    logic        sample_stb;
    logic        shift_stb;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit alt_en = 1'b0;
    bit cmp_en = 1'b0;

    // Model state
    int m_div = 1;
    int m_hi = 0;
    bit m_src = 1'b0;
    bit m_act = 1'b0;
    int m_pos = 0;
    bit m_sck = 1'b0;
    bit m_smp = 1'b0;
    bit m_shf = 1'b0;

    always #5 clk = ~clk;

    spi_sck_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .alt_tick  (alt_tick),
        .cfg_wr    (cfg_wr),
        .cfg_data  (cfg_data),
        .sck       (sck),
        .sample_stb(sample_stb),
        .shift_stb (shift_stb)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Behavioural model, updated at every rising edge from the stable inputs.
    always @(posedge clk) begin
        bit tk;
        bit lvl;
        int d;
        int h;
        cyc++;
        if (!rst_n) begin
            m_div = 1; m_hi = 0; m_src = 0; m_act = 0; m_pos = 0;
            m_sck = 0; m_smp = 0; m_shf = 0;
        end else begin
            tk = m_src ? alt_tick : 1'b1;
            if (cfg_wr && !run) begin
                d = int'(cfg_data[17:12]);
                if (d == 0) d = 1;
                h = int'(cfg_data[11:6]);
                if (h >= d) h = d - 1;
                m_div = d; m_hi = h; m_src = cfg_data[31];
            end
            if (!run) begin
                m_act = 0; m_pos = 0; m_sck = 0; m_smp = 0; m_shf = 0;
            end else if (!m_act) begin
                m_act = 1; m_pos = 0; m_sck = 1; m_smp = 1; m_shf = 0;
            end else if (tk) begin
                m_pos = (m_pos + 1) % (m_div + 1);
                lvl = (m_pos <= m_hi);
                m_smp = lvl && !m_sck;
                m_shf = !lvl && m_sck;
                m_sck = lvl;
            end else begin
                m_smp = 0; m_shf = 0;
            end
        end
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual %0d expected below %0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            check(sck == m_sck, "R3", "sck level", int'(sck), int'(m_sck));
            check(sample_stb == m_smp, "R5", "sample_stb", int'(sample_stb), int'(m_smp));
            check(shift_stb == m_shf, "R5", "shift_stb", int'(shift_stb), int'(m_shf));
        end
    end

    // Periodic step enable for the alternate source (every third cycle).
    always @(negedge clk) begin
        alt_tick <= alt_en && (cyc % 3 == 0);
    end

    function automatic logic [31:0] word(input bit src, input int dv, input int hv, input int lv);
        logic [31:0] w;
        w = '0;
        w[31]    = src;
        w[17:12] = 6'(dv);
        w[11:6]  = 6'(hv);
        w[5:0]   = 6'(lv);
        return w;
    endfunction

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Measures cycles between successive sample strobes and the SCK high cycles in that span.
    task automatic measure(output int per, output int hl);
        @(negedge clk);
        while (!sample_stb) @(negedge clk);
        per = 0;
        hl = 0;
        do begin
            if (sck) hl++;
            per++;
            @(negedge clk);
        end while (!sample_stb);
    endtask

    task automatic run_and_check(input string req, input int exp_per, input int exp_hi);
        int per;
        int hl;
        @(negedge clk);
        run = 1'b1;
        measure(per, hl);
        measure(per, hl);
        check(per == exp_per, req, "period", per, exp_per);
        check(hl == exp_hi, req, "high time", hl, exp_hi);
        @(negedge clk);
        run = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int per;
        int hl;
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        check(sck == 1'b0, "R1", "sck in reset", int'(sck), 0);
        check(sample_stb == 1'b0, "R1", "sample_stb in reset", int'(sample_stb), 0);
        check(shift_stb == 1'b0, "R1", "shift_stb in reset", int'(shift_stb), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1: default word gives a two-cycle SCK
        run_and_check("R1", 2, 1);

        // R4: first run cycle raises sck with a sample strobe; idle drops it
        write_cfg(word(0, 5, 2, 5));
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        check(sck == 1'b1, "R4", "sck after start", int'(sck), 1);
        check(sample_stb == 1'b1, "R4", "sample at start", int'(sample_stb), 1);
        repeat (4) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check(sck == 1'b0, "R4", "sck after stop", int'(sck), 0);
        check(shift_stb == 1'b0 && sample_stb == 1'b0, "R4", "strobes after stop",
              int'(shift_stb) + int'(sample_stb), 0);
        repeat (2) @(negedge clk);

        // R2 and R3: several period and high settings, including the slowest
        run_and_check("R2", 6, 3);
        write_cfg(word(0, 7, 0, 1));
        run_and_check("R3", 8, 1);
        write_cfg(word(0, 63, 31, 63));
        run_and_check("R2", 64, 32);

        // R10: the low-count field does not alter the waveform
        write_cfg(word(0, 5, 2, 0));
        run_and_check("R10", 6, 3);
        write_cfg(word(0, 5, 2, 63) | 32'h7FFC_0000);
        run_and_check("R10", 6, 3);

        // R6: a write during a transfer is discarded
        write_cfg(word(0, 3, 1, 3));
        @(negedge clk);
        run = 1'b1;
        measure(per, hl);
        cfg_wr = 1'b1;
        cfg_data = word(0, 9, 4, 9);
        @(negedge clk);
        cfg_wr = 1'b0;
        measure(per, hl);
        measure(per, hl);
        check(per == 4, "R6", "period after busy write", per, 4);
        @(negedge clk);
        run = 1'b0;
        repeat (2) @(negedge clk);
        run_and_check("R6", 4, 2);

        // R8: period value 0 behaves as 1
        write_cfg(word(0, 0, 0, 0));
        run_and_check("R8", 2, 1);

        // R9: oversized high value is clamped below the period
        write_cfg(word(0, 4, 10, 4));
        run_and_check("R9", 5, 4);

        // R7: alternate source steps only on alt_tick
        alt_en = 1'b1;
        write_cfg(word(1, 3, 1, 3));
        run_and_check("R7", 12, 6);
        // R7: with the internal source, alt_tick is ignored
        write_cfg(word(0, 3, 1, 3));
        run_and_check("R7", 4, 2);
        alt_en = 1'b0;

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule